// File: doc/BRIEF.md
# Privileged-Mode Exception Entry Unit

This block handles the entry half of exception processing. When `exc_valid` is high, it decodes the cause. Fixed causes map to one vector slot each. Privileged-call causes map to a 64-byte slot chosen by the call code. The unit then computes a redirect address relative to the privileged-code base register. It records the interrupted PC with the current mode folded into bit 0, and raises the privileged-mode flag.

If the core was running in normal mode when the exception arrived, the unit also exchanges eight architectural integer registers with a private shadow bank. The exchange takes one clock edge. It uses the register file held inside the block. That register file has one ordinary write port and a registered side read port that can reach either bank.

Causes that are not valid entry causes, and call codes in the reserved ranges, produce no entry. Instead they pulse an error output. In that case the PC and mode outputs take the current values unchanged, and both register banks are left untouched.

Top module: `exc_entry_unit`

## Requirements
- R1: After synchronous reset, `next_pc`, `saved_pc`, `next_priv`, `entry_taken`, `entry_error` are all zero and every register of both banks reads zero.
- R2: Fixed cause codes 0..9 (reset, machine check, interprocessor interrupt, clock interrupt, device interrupt, memory-management fault, unaligned access, illegal opcode, arithmetic trap, floating-point disabled) select offset cause × 0x80.
- R3: Cause 10 is a privileged call. If call code bit 7 is set, the offset is 0x2000 + code[5:0] × 64; otherwise it is 0x1000 + code[5:0] × 64.
- R4: One cycle after an accepted request, `next_pc` equals `priv_base` plus the offset, `next_priv` is 1 and `entry_taken` pulses for one cycle.
- R5: On an accepted request, `saved_pc` becomes `cur_pc` ORed with `cur_priv` in bit 0.
- R6: An accepted request with `cur_priv`=0 exchanges registers 8..14 and 25 with shadow slots 0..7, in that order, on one edge.
- R7: An accepted request with `cur_priv`=1 leaves both banks unchanged.
- R8: Cause codes 11..15 pulse `entry_error` and do not pulse `entry_taken`. `next_pc` takes `cur_pc` and `next_priv` takes `cur_priv`. `saved_pc` and both banks are unchanged.
- R9: With cause 10, call codes whose bit 6 is set (0x40..0x7F, 0xC0..0xFF) are treated like R8.
- R10: A register write issued in the same cycle as a swapping entry, to a register being swapped, lands in the matching shadow slot. The register itself receives the old shadow value.
- R11: With `exc_valid` low, `next_pc`, `saved_pc` and `next_priv` hold, and both pulses are low.
- R12: The side read port returns, one cycle after the request, register `rf_rd_idx` when `rf_rd_shadow`=0, or shadow slot `rf_rd_idx[2:0]` when `rf_rd_shadow`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid | input | 1 | Exception request this cycle |
| exc_cause | input | 4 | Cause code |
| pcall_code | input | 8 | Privileged-call code |
| cur_pc | input | 64 | PC of the interrupted instruction |
| cur_priv | input | 1 | Current privileged-mode flag |
| priv_base | input | 64 | Base address of privileged code |
| rf_wr_en | input | 1 | Register write enable |
| rf_wr_idx | input | 5 | Register write index |
| rf_wr_data | input | 64 | Register write data |
| rf_rd_shadow | input | 1 | Side read selects shadow bank |
| rf_rd_idx | input | 5 | Side read index |
| rf_rd_data | output | 64 | Side read data (registered) |
| next_pc | output | 64 | Redirected PC |
| saved_pc | output | 64 | Saved exception address with mode in bit 0 |
| next_priv | output | 1 | New privileged-mode flag |
| entry_taken | output | 1 | Pulse: entry performed |
| entry_error | output | 1 | Pulse: request rejected |

## Verification
A swapping entry and an ordinary register write can land on the same clock edge, and both touch the same storage. The bench provokes this by writing register 9 in the same cycle as a cause-0 request made from normal mode. It then reads both banks through the side port. The new data must appear in shadow slot 1, and register 9 must hold the value that shadow slot 1 carried before that edge. A rejected request from normal mode is also shown to leave both banks intact.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int CAUSE_W = 4;
  localparam logic [CAUSE_W-1:0] CZ_LAST_FIXED = 4'd9;
  localparam logic [CAUSE_W-1:0] CZ_PCALL      = 4'd10;
  localparam int OFF_W         = 14;
  localparam int FIXED_SHIFT   = 7;
  localparam int SLOT_SHIFT    = 6;
  localparam int PRIV_REGION   = 'h1000;
  localparam int UNPRIV_REGION = 'h2000;
endpackage

// File: rtl/exc_vec_calc.sv
module exc_vec_calc
  import exc_entry_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic [CAUSE_W-1:0] cause,
  input  logic [CODE_W-1:0]  code,
  output logic [OFF_W-1:0]   offset,
  output logic               illegal
);
  localparam int SLOT_W = CODE_W - 2;

  always_comb begin
    offset  = '0;
    illegal = 1'b0;
    if (cause <= CZ_LAST_FIXED) begin
      offset = OFF_W'(cause) << FIXED_SHIFT;
    end else if (cause == CZ_PCALL) begin
      if (code[CODE_W-2]) begin
        illegal = 1'b1;
      end else begin
        offset = (code[CODE_W-1] ? OFF_W'(UNPRIV_REGION) : OFF_W'(PRIV_REGION))
               + (OFF_W'(code[SLOT_W-1:0]) << SLOT_SHIFT);
      end
    end else begin
      illegal = 1'b1;
    end
  end
endmodule

// File: rtl/exc_shadow_rf.sv
module exc_shadow_rf #(
  parameter int XLEN    = 64,
  parameter int NREGS   = 32,
  parameter int NSHADOW = 8,
  parameter int LO_BASE = 8,
  parameter int HI_IDX  = 25
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      swap_en,
  input  logic                      wr_en,
  input  logic [$clog2(NREGS)-1:0]  wr_idx,
  input  logic [XLEN-1:0]           wr_data,
  input  logic                      rd_shadow,
  input  logic [$clog2(NREGS)-1:0]  rd_idx,
  output logic [XLEN-1:0]           rd_data
);
  localparam int IDX_W = $clog2(NREGS);
  localparam int SH_W  = $clog2(NSHADOW);

  function automatic int map_idx(input int k);
    return (k < NSHADOW - 1) ? LO_BASE + k : HI_IDX;
  endfunction

  localparam int MAP_FIRST = map_idx(0);
  localparam int MAP_LAST  = map_idx(NSHADOW - 1);

  logic [XLEN-1:0] regs   [NREGS];
  logic [XLEN-1:0] shadow [NSHADOW];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
      for (int k = 0; k < NSHADOW; k++) shadow[k] <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en) regs[wr_idx] <= wr_data;
      if (swap_en) begin
        for (int k = 0; k < NSHADOW; k++) begin
          shadow[k] <= (wr_en && wr_idx == IDX_W'(map_idx(k))) ? wr_data
                                                              : regs[map_idx(k)];
          regs[map_idx(k)] <= shadow[k];
        end
      end
      rd_data <= rd_shadow ? shadow[rd_idx[SH_W-1:0]] : regs[rd_idx];
    end
  end

  // R6: first and last slots exchange on one edge
  a_r6_swap_first: assert property (@(posedge clk) disable iff (rst)
    (swap_en && !wr_en) |=> (shadow[0] == $past(regs[MAP_FIRST]) &&
                             regs[MAP_FIRST] == $past(shadow[0])));
  a_r6_swap_last: assert property (@(posedge clk) disable iff (rst)
    (swap_en && !wr_en) |=> (shadow[NSHADOW-1] == $past(regs[MAP_LAST]) &&
                             regs[MAP_LAST] == $past(shadow[NSHADOW-1])));
  // R7: shadow bank is quiet without a swap
  a_r7_shadow_quiet: assert property (@(posedge clk) disable iff (rst)
    !swap_en |=> ($stable(shadow[0]) && $stable(shadow[NSHADOW-1])));
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int NREGS   = 32,
  parameter int NSHADOW = 8,
  parameter int CODE_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     exc_valid,
  input  logic [3:0]               exc_cause,
  input  logic [CODE_W-1:0]        pcall_code,
  input  logic [XLEN-1:0]          cur_pc,
  input  logic                     cur_priv,
  input  logic [XLEN-1:0]          priv_base,
  input  logic                     rf_wr_en,
  input  logic [$clog2(NREGS)-1:0] rf_wr_idx,
  input  logic [XLEN-1:0]          rf_wr_data,
  input  logic                     rf_rd_shadow,
  input  logic [$clog2(NREGS)-1:0] rf_rd_idx,
  output logic [XLEN-1:0]          rf_rd_data,
  output logic [XLEN-1:0]          next_pc,
  output logic [XLEN-1:0]          saved_pc,
  output logic                     next_priv,
  output logic                     entry_taken,
  output logic                     entry_error
);
  logic [OFF_W-1:0] vec_off;
  logic             vec_bad;
  logic             take;
  logic             swap_en;

  exc_vec_calc #(.CODE_W(CODE_W)) u_vec (
    .cause   (exc_cause),
    .code    (pcall_code),
    .offset  (vec_off),
    .illegal (vec_bad)
  );

  assign take    = exc_valid && !vec_bad;
  assign swap_en = take && !cur_priv;

  exc_shadow_rf #(.XLEN(XLEN), .NREGS(NREGS), .NSHADOW(NSHADOW)) u_rf (
    .clk       (clk),
    .rst       (rst),
    .swap_en   (swap_en),
    .wr_en     (rf_wr_en),
    .wr_idx    (rf_wr_idx),
    .wr_data   (rf_wr_data),
    .rd_shadow (rf_rd_shadow),
    .rd_idx    (rf_rd_idx),
    .rd_data   (rf_rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      next_pc     <= '0;
      saved_pc    <= '0;
      next_priv   <= 1'b0;
      entry_taken <= 1'b0;
      entry_error <= 1'b0;
    end else begin
      entry_taken <= take;
      entry_error <= exc_valid && vec_bad;
      if (take) begin
        next_pc   <= priv_base + XLEN'(vec_off);
        saved_pc  <= cur_pc | XLEN'(cur_priv);
        next_priv <= 1'b1;
      end else if (exc_valid) begin
        next_pc   <= cur_pc;
        next_priv <= cur_priv;
      end
    end
  end

  // R4: accepted request leads to privileged mode and a taken pulse
  a_r4_enter_priv: assert property (@(posedge clk) disable iff (rst)
    take |=> (entry_taken && next_priv));
  // R8: rejected request keeps PC, mode and saved address
  a_r8_reject_keeps: assert property (@(posedge clk) disable iff (rst)
    (exc_valid && vec_bad) |=> (entry_error && !entry_taken &&
      next_pc == $past(cur_pc) && next_priv == $past(cur_priv) && $stable(saved_pc)));
  // R11: idle cycles hold outputs
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !exc_valid |=> (!entry_taken && !entry_error && $stable(next_pc) &&
                    $stable(saved_pc) && $stable(next_priv)));
endmodule

// File: tb/exc_entry_unit_tb.sv
module exc_entry_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        exc_valid;
  logic [3:0]  exc_cause;
  logic [7:0]  pcall_code;
  logic [63:0] cur_pc;
  logic        cur_priv;
  logic [63:0] priv_base;
  logic        rf_wr_en;
  logic [4:0]  rf_wr_idx;
  logic [63:0] rf_wr_data;
  logic        rf_rd_shadow;
  logic [4:0]  rf_rd_idx;
  logic [63:0] rf_rd_data;
  logic [63:0] next_pc;
  logic [63:0] saved_pc;
  logic        next_priv;
  logic        entry_taken;
  logic        entry_error;

  int total = 0;
  int bad   = 0;
  logic [63:0] last_saved;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_unit u_dut (
    .clk(clk), .rst(rst), .exc_valid(exc_valid), .exc_cause(exc_cause),
    .pcall_code(pcall_code), .cur_pc(cur_pc), .cur_priv(cur_priv),
    .priv_base(priv_base), .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx),
    .rf_wr_data(rf_wr_data), .rf_rd_shadow(rf_rd_shadow), .rf_rd_idx(rf_rd_idx),
    .rf_rd_data(rf_rd_data), .next_pc(next_pc), .saved_pc(saved_pc),
    .next_priv(next_priv), .entry_taken(entry_taken), .entry_error(entry_error)
  );

  typedef struct packed {
    logic [3:0]  cause;
    logic [7:0]  code;
    logic        mode;
    logic [63:0] pc;
    logic [63:0] base;
    logic [63:0] exp_pc;
    logic        exp_err;
  } vec_t;

  localparam int NVEC = 20;
  localparam vec_t TBL [NVEC] = '{
    '{4'd0,  8'h00, 1'b1, 64'h0000_0000_0000_0100, 64'h8000, 64'h8000, 1'b0},
    '{4'd1,  8'h00, 1'b1, 64'h0000_0000_0000_0104, 64'h8000, 64'h8080, 1'b0},
    '{4'd2,  8'h00, 1'b0, 64'h0000_0000_0000_0200, 64'h8000, 64'h8100, 1'b0},
    '{4'd3,  8'h00, 1'b1, 64'h0000_0000_0000_0204, 64'h8000, 64'h8180, 1'b0},
    '{4'd4,  8'h00, 1'b1, 64'h0000_0000_0000_0208, 64'h8000, 64'h8200, 1'b0},
    '{4'd5,  8'h00, 1'b1, 64'h0000_0000_0000_0300, 64'h10000, 64'h10280, 1'b0},
    '{4'd6,  8'h00, 1'b1, 64'h0000_0000_0000_0304, 64'h10000, 64'h10300, 1'b0},
    '{4'd7,  8'h00, 1'b1, 64'h0000_0000_0000_0308, 64'h10000, 64'h10380, 1'b0},
    '{4'd8,  8'h00, 1'b0, 64'hFFFF_0000_0000_0400, 64'h4000_0000, 64'h4000_0400, 1'b0},
    '{4'd9,  8'h00, 1'b1, 64'h0000_0000_0000_0404, 64'h4000_0000, 64'h4000_0480, 1'b0},
    '{4'd10, 8'h00, 1'b1, 64'h0000_0000_0000_0500, 64'h20_0000, 64'h20_1000, 1'b0},
    '{4'd10, 8'h3F, 1'b1, 64'h0000_0000_0000_0504, 64'h20_0000, 64'h20_1FC0, 1'b0},
    '{4'd10, 8'h80, 1'b1, 64'h0000_0000_0000_0508, 64'h20_0000, 64'h20_2000, 1'b0},
    '{4'd10, 8'h83, 1'b0, 64'h0000_0000_0000_050C, 64'h20_0000, 64'h20_20C0, 1'b0},
    '{4'd10, 8'hBF, 1'b1, 64'h0000_0000_0000_0510, 64'h20_0000, 64'h20_2FC0, 1'b0},
    '{4'd11, 8'h00, 1'b1, 64'h0000_0000_0000_0600, 64'h8000, 64'h600, 1'b1},
    '{4'd12, 8'h00, 1'b0, 64'h0000_0000_0000_0604, 64'h8000, 64'h604, 1'b1},
    '{4'd15, 8'h00, 1'b1, 64'h0000_0000_0000_0608, 64'h8000, 64'h608, 1'b1},
    '{4'd10, 8'h40, 1'b0, 64'h0000_0000_0000_060C, 64'h8000, 64'h60C, 1'b1},
    '{4'd10, 8'hC5, 1'b1, 64'h0000_0000_0000_0610, 64'h8000, 64'h610, 1'b1}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fire(input logic [3:0] c, input logic [7:0] code, input logic m,
                      input logic [63:0] pc, input logic [63:0] base,
                      input logic we, input logic [4:0] widx, input logic [63:0] wdat);
    @(negedge clk);
    exc_valid = 1'b1; exc_cause = c; pcall_code = code; cur_priv = m;
    cur_pc = pc; priv_base = base;
    rf_wr_en = we; rf_wr_idx = widx; rf_wr_data = wdat;
    @(negedge clk);
    exc_valid = 1'b0; rf_wr_en = 1'b0;
  endtask

  task automatic wr(input logic [4:0] idx, input logic [63:0] d);
    @(negedge clk);
    rf_wr_en = 1'b1; rf_wr_idx = idx; rf_wr_data = d;
    @(negedge clk);
    rf_wr_en = 1'b0;
  endtask

  task automatic rd(input logic sh, input logic [4:0] idx, output logic [63:0] d);
    @(negedge clk);
    rf_rd_shadow = sh; rf_rd_idx = idx;
    @(negedge clk);
    d = rf_rd_data;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] d;
    rst = 1'b1; exc_valid = 1'b0; exc_cause = '0; pcall_code = '0; cur_pc = '0;
    cur_priv = 1'b0; priv_base = '0; rf_wr_en = 1'b0; rf_wr_idx = '0;
    rf_wr_data = '0; rf_rd_shadow = 1'b0; rf_rd_idx = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 next_pc", next_pc, 64'h0);
    check("R1 saved_pc", saved_pc, 64'h0);
    check("R1 mode/pulses", {61'h0, next_priv, entry_taken, entry_error}, 64'h0);
    rd(1'b0, 5'd8, d);  check("R1 reg8", d, 64'h0);
    rd(1'b1, 5'd7, d);  check("R1 shadow7", d, 64'h0);
    last_saved = 64'h0;

    // R2 R3 R4 R5 R8 R9 table walk
    for (int i = 0; i < NVEC; i++) begin
      fire(TBL[i].cause, TBL[i].code, TBL[i].mode, TBL[i].pc, TBL[i].base,
           1'b0, 5'd0, 64'h0);
      check("R2/R3/R4 next_pc", next_pc, TBL[i].exp_pc);
      check("R4/R8/R9 pulses", {62'h0, entry_taken, entry_error},
            TBL[i].exp_err ? 64'h1 : 64'h2);
      if (TBL[i].exp_err) begin
        check("R8/R9 mode kept", {63'h0, next_priv}, {63'h0, TBL[i].mode});
        check("R8 saved held", saved_pc, last_saved);
      end else begin
        last_saved = TBL[i].pc | {63'h0, TBL[i].mode};
        check("R4 mode set", {63'h0, next_priv}, 64'h1);
        check("R5 saved_pc", saved_pc, last_saved);
      end
    end

    // R11 idle hold
    @(negedge clk);
    check("R11 hold pc", next_pc, 64'h610);
    check("R11 pulses low", {62'h0, entry_taken, entry_error}, 64'h0);

    // load registers, shadows currently zero after even number of swaps? set them
    for (int r = 8; r <= 14; r++) wr(5'(r), 64'h1000 + 64'(r));
    wr(5'd25, 64'h1019);
    rd(1'b0, 5'd8, d);  check("R12 read reg8", d, 64'h1008);
    // R6 swap from normal mode
    fire(4'd0, 8'h00, 1'b0, 64'h700, 64'h8000, 1'b0, 5'd0, 64'h0);
    rd(1'b1, 5'd0, d);  check("R6 shadow0", d, 64'h1008);
    rd(1'b1, 5'd7, d);  check("R6 shadow7 gets reg25", d, 64'h1019);
    rd(1'b1, 5'd6, d);  check("R6 shadow6 gets reg14", d, 64'h100E);
    // R7 no swap in privileged mode
    fire(4'd1, 8'h00, 1'b1, 64'h704, 64'h8000, 1'b0, 5'd0, 64'h0);
    rd(1'b1, 5'd0, d);  check("R7 shadow0 kept", d, 64'h1008);
    // R8 rejected from normal mode: no swap
    fire(4'd13, 8'h00, 1'b0, 64'h708, 64'h8000, 1'b0, 5'd0, 64'h0);
    rd(1'b1, 5'd1, d);  check("R8 shadow1 kept", d, 64'h1009);
    // R10 write concurrent with swap
    wr(5'd9, 64'h5555);
    fire(4'd0, 8'h00, 1'b0, 64'h70C, 64'h8000, 1'b1, 5'd9, 64'hABCD);
    rd(1'b1, 5'd1, d);  check("R10 shadow1 gets write", d, 64'hABCD);
    rd(1'b0, 5'd9, d);  check("R10 reg9 gets old shadow", d, 64'h1009);
    rd(1'b0, 5'd3, d);  check("R12 non-swapped reg", d, 64'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule